// File: doc/BRIEF.md
# Dual-Rail Serial Word Receiver

This block takes a serial stream sent on two rails: one rail pulses for a zero bit, the other for a one bit, and both rails low is the null state that separates bits. The rails are sampled by a clock at four times the bit rate. Each rail is synchronised and then qualified by a short persistence filter. Accepted bits are packed into a 32-bit word, least significant bit first.

A word ends when the line stays null for a gap of several bit times. The receiver then checks that exactly 32 bits arrived and, when parity checking is on, that the word has odd parity. In word mode a clean word is delivered whole. In byte mode each group of eight bits is delivered as soon as it is complete, and the checks still run at the end of the word. A host read strobe takes the data and clears the flags. A delivery that lands on data not yet taken raises an overwrite flag.

Top module: `rxdr_rx`

## Requirements
- R1: A sample with `rail_zero` high and `rail_one` low carries a 0 bit, and the reverse carries a 1 bit. Samples with both rails high produce no bit. Both rails low is null.
- R2: A rail pulse gives exactly one bit, and only if it stays high for at least 2 consecutive sample clocks. A pulse of 1 sample clock is dropped.
- R3: 16 consecutive null sample clocks (4 bit times) end a word. After reset, bits are ignored until the first such gap.
- R4: The first bit received lands in `data_out[0]` and the 32nd lands in `data_out[31]`.
- R5: In word mode (`byte_mode`=0), a word of exactly 32 bits that passes the parity rule sets `data_out` to the word and sets `data_rdy`=1 and `first_flag`=1.
- R6: A word whose bit count is not 32 sets `err_frame`=1, leaves `err_parity` at 0 and raises no `data_rdy` in word mode.
- R7: With `parity_en`=1, a 32-bit word with an even number of ones sets `err_parity`=1 and raises no `data_rdy` in word mode. With `parity_en`=0, no parity error is raised and bit 31 is kept as plain data.
- R8: In byte mode, each completed group of 8 bits puts the byte on `data_out[7:0]` with zeros above it and sets `data_rdy`=1. `first_flag` is 1 only for the first byte of a word. No `data_rdy` is raised at the end of the word.
- R9: A delivery while `data_rdy` is still 1, with no `rd_ack` in the same cycle, sets `err_overrun`=1 and replaces the data.
- R10: After reset all outputs are 0. `rd_ack` clears `data_rdy`, `first_flag` and all error flags. A delivery or error in the same cycle as `rd_ack` wins over the clear, and such a delivery does not raise `err_overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_zero | input | 1 | Line rail that pulses for a 0 bit |
| rail_one | input | 1 | Line rail that pulses for a 1 bit |
| byte_mode | input | 1 | 1: deliver bytes as they complete; 0: deliver whole words |
| parity_en | input | 1 | 1: require odd parity over the 32 bits |
| rd_ack | input | 1 | Host read strobe; takes the data and clears the flags |
| data_out | output | 32 | Delivered word, or byte in bits 7:0 |
| data_rdy | output | 1 | Data waiting for the host |
| first_flag | output | 1 | First byte of a word (byte mode) or valid word (word mode) |
| err_parity | output | 1 | Last full-length word had even parity |
| err_frame | output | 1 | Last word did not have exactly 32 bits |
| err_overrun | output | 1 | Unread data was replaced |

## Verification
The host read strobe and a new delivery can land in the same clock cycle. In that cycle the delivery must win and no overwrite may be reported. To provoke this, the bench leaves one word unread, sends a second word, and during the closing gap moves a one-cycle `rd_ack` across a window of offsets that spans the delivery edge. It notes at the ports the cycle in which `data_out` takes the new word. It then expects `data_rdy` to stay set if the strobe came at or before that edge and to be clear if it came after. It expects `err_overrun` to be clear for every offset.

// File: rtl/rxdr_pkg.sv
package rxdr_pkg;

  localparam int RAIL_COUNT    = 2;
  localparam int RAIL_ZERO_IDX = 0;
  localparam int RAIL_ONE_IDX  = 1;

  typedef struct packed {
    logic stb;
    logic frame_ok;
    logic parity_ok;
  } word_end_t;

endpackage

// File: rtl/rxdr_rail_qual.sv
module rxdr_rail_qual #(
  parameter int QUAL_SAMPLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_rail,
  input  logic other_sync,
  output logic rail_sync,
  output logic hit
);

  localparam int CW = $clog2(QUAL_SAMPLES + 1);
  localparam logic [CW-1:0] Q_MAX = CW'(QUAL_SAMPLES);
  localparam logic [CW-1:0] Q_HIT = CW'(QUAL_SAMPLES - 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], raw_rail};
  end

  assign rail_sync = sync_q[1];
  assign lone      = rail_sync & ~other_sync;

  always_comb begin
    cnt_d = cnt_q;
    if (!lone)             cnt_d = '0;
    else if (cnt_q < Q_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = lone && (cnt_q == Q_HIT);

  AST_ONE_HIT_PER_PULSE: assert property (@(posedge clk) disable iff (!rst_n) hit |=> !hit); // R2
  AST_NO_HIT_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (rail_sync && other_sync) |-> !hit); // R1

endmodule

// File: rtl/rxdr_gap_det.sv
module rxdr_gap_det #(
  parameter int GAP_SAMPLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic null_smp,
  output logic gap_stb,
  output logic armed
);

  localparam int GW = $clog2(GAP_SAMPLES + 1);
  localparam logic [GW-1:0] G_MAX = GW'(GAP_SAMPLES);
  localparam logic [GW-1:0] G_HIT = GW'(GAP_SAMPLES - 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          armed_q, armed_d;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (!null_smp)          cnt_d = '0;
    else if (cnt_q < G_MAX) cnt_d = cnt_q + 1'b1;
    if (gap_stb)            armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign gap_stb = null_smp && (cnt_q == G_HIT);
  assign armed   = armed_q;

  AST_GAP_ONCE: assert property (@(posedge clk) disable iff (!rst_n) gap_stb |=> !gap_stb); // R3
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n) armed |=> armed); // R3

endmodule

// File: rtl/rxdr_word_asm.sv
module rxdr_word_asm
  import rxdr_pkg::*;
#(
  parameter int WORD_BITS = 32,  // power of two
  parameter int BYTE_BITS = 8    // power of two, divides WORD_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_vld,
  input  logic                 bit_val,
  input  logic                 armed,
  input  logic                 gap_stb,
  input  logic                 byte_mode,
  input  logic                 parity_en,
  output logic [WORD_BITS-1:0] word_q,
  output logic                 byte_stb,
  output logic [$clog2(WORD_BITS/BYTE_BITS)-1:0] byte_idx,
  output word_end_t            word_end
);

  localparam int BIT_IW  = $clog2(WORD_BITS);
  localparam int BYTE_SH = $clog2(BYTE_BITS);
  localparam int IDX_W   = BIT_IW - BYTE_SH;
  localparam int CNT_W   = $clog2(WORD_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_BITS + 1);

  logic [WORD_BITS-1:0] word_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic                 byte_stb_q, byte_stb_d;
  logic [IDX_W-1:0]     byte_idx_q, byte_idx_d;
  word_end_t            end_q, end_d;
  logic                 take;

  assign take = bit_vld & armed;

  always_comb begin
    word_d     = word_q;
    cnt_d      = cnt_q;
    byte_stb_d = 1'b0;
    byte_idx_d = byte_idx_q;
    end_d      = end_q;
    end_d.stb  = 1'b0;
    if (gap_stb && (cnt_q != '0)) begin
      end_d.stb       = 1'b1;
      end_d.frame_ok  = (cnt_q == CNT_FULL);
      end_d.parity_ok = !parity_en || (^word_q);
      cnt_d           = '0;
    end else if (take) begin
      if (cnt_q < CNT_FULL) begin
        word_d[cnt_q[BIT_IW-1:0]] = bit_val;
        if (byte_mode && (&cnt_q[BYTE_SH-1:0])) begin
          byte_stb_d = 1'b1;
          byte_idx_d = cnt_q[BIT_IW-1:BYTE_SH];
        end
      end
      if (cnt_q < CNT_OVER) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q     <= '0;
      cnt_q      <= '0;
      byte_stb_q <= 1'b0;
      byte_idx_q <= '0;
      end_q      <= '0;
    end else begin
      word_q     <= word_d;
      cnt_q      <= cnt_d;
      byte_stb_q <= byte_stb_d;
      byte_idx_q <= byte_idx_d;
      end_q      <= end_d;
    end
  end

  assign byte_stb = byte_stb_q;
  assign byte_idx = byte_idx_q;
  assign word_end = end_q;

  AST_UNARMED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) !armed |-> (cnt_q == '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_OVER); // R6
  AST_NO_BIT_AT_GAP: assert property (@(posedge clk) disable iff (!rst_n) !(gap_stb && bit_vld)); // R3
  AST_END_CLEARS_CNT: assert property (@(posedge clk) disable iff (!rst_n) end_d.stb |=> (cnt_q == '0)); // R6

endmodule

// File: rtl/rxdr_rx.sv
module rxdr_rx
  import rxdr_pkg::*;
#(
  parameter int WORD_BITS    = 32,
  parameter int BYTE_BITS    = 8,
  parameter int OVERSAMPLE   = 4,
  parameter int QUAL_SAMPLES = 2,
  parameter int GAP_BITS     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rail_zero,
  input  logic                 rail_one,
  input  logic                 byte_mode,
  input  logic                 parity_en,
  input  logic                 rd_ack,
  output logic [WORD_BITS-1:0] data_out,
  output logic                 data_rdy,
  output logic                 first_flag,
  output logic                 err_parity,
  output logic                 err_frame,
  output logic                 err_overrun
);

  localparam int GAP_SAMPLES = OVERSAMPLE * GAP_BITS;
  localparam int BIT_IW      = $clog2(WORD_BITS);
  localparam int BYTE_SH     = $clog2(BYTE_BITS);
  localparam int IDX_W       = BIT_IW - BYTE_SH;

  logic [RAIL_COUNT-1:0] raw, rsync, hit;
  logic                  null_smp, bit_vld, bit_val;
  logic                  gap_stb, armed;
  logic [WORD_BITS-1:0]  word_q;
  logic                  byte_stb;
  logic [IDX_W-1:0]      byte_idx;
  word_end_t             word_end;

  assign raw[RAIL_ZERO_IDX] = rail_zero;
  assign raw[RAIL_ONE_IDX]  = rail_one;

  for (genvar g = 0; g < RAIL_COUNT; g++) begin : g_rail
    rxdr_rail_qual #(.QUAL_SAMPLES(QUAL_SAMPLES)) u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .raw_rail  (raw[g]),
      .other_sync(rsync[RAIL_COUNT-1-g]),
      .rail_sync (rsync[g]),
      .hit       (hit[g])
    );
  end

  assign null_smp = ~|rsync;
  assign bit_vld  = |hit;
  assign bit_val  = hit[RAIL_ONE_IDX];

  rxdr_gap_det #(.GAP_SAMPLES(GAP_SAMPLES)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .null_smp(null_smp),
    .gap_stb (gap_stb),
    .armed   (armed)
  );

  rxdr_word_asm #(.WORD_BITS(WORD_BITS), .BYTE_BITS(BYTE_BITS)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_vld  (bit_vld),
    .bit_val  (bit_val),
    .armed    (armed),
    .gap_stb  (gap_stb),
    .byte_mode(byte_mode),
    .parity_en(parity_en),
    .word_q   (word_q),
    .byte_stb (byte_stb),
    .byte_idx (byte_idx),
    .word_end (word_end)
  );

  // Flag and data register
  logic [WORD_BITS-1:0] data_q, data_d;
  logic                 rdy_q, rdy_d, first_q, first_d;
  logic                 par_q, par_d, frm_q, frm_d, ovr_q, ovr_d;
  logic                 word_ok, deliver, data_en;
  logic [BIT_IW-1:0]    byte_base;
  logic [BYTE_BITS-1:0] byte_sel;

  assign byte_base = {byte_idx, {BYTE_SH{1'b0}}};
  assign byte_sel  = word_q[byte_base +: BYTE_BITS];
  assign word_ok   = word_end.stb && word_end.frame_ok && word_end.parity_ok && !byte_mode;
  assign deliver   = byte_stb || word_ok;
  assign data_en   = deliver;

  always_comb begin
    data_d = '0;
    if (byte_stb) data_d[BYTE_BITS-1:0] = byte_sel;
    else          data_d = word_q;

    rdy_d   = rd_ack ? 1'b0 : rdy_q;
    first_d = rd_ack ? 1'b0 : first_q;
    par_d   = rd_ack ? 1'b0 : par_q;
    frm_d   = rd_ack ? 1'b0 : frm_q;
    ovr_d   = rd_ack ? 1'b0 : ovr_q;

    if (deliver) begin
      rdy_d = 1'b1;
      if (rdy_q && !rd_ack) ovr_d = 1'b1;
    end
    if (byte_stb) first_d = (byte_idx == '0);
    if (word_ok)  first_d = 1'b1;
    if (word_end.stb && !word_end.frame_ok) frm_d = 1'b1;
    if (word_end.stb && word_end.frame_ok && !word_end.parity_ok) par_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      first_q <= 1'b0;
      par_q   <= 1'b0;
      frm_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      rdy_q   <= rdy_d;
      first_q <= first_d;
      par_q   <= par_d;
      frm_q   <= frm_d;
      ovr_q   <= ovr_d;
    end
  end

  assign data_out    = data_q;
  assign data_rdy    = rdy_q;
  assign first_flag  = first_q;
  assign err_parity  = par_q;
  assign err_frame   = frm_q;
  assign err_overrun = ovr_q;

  AST_BOTH_HIGH_NO_BIT: assert property (@(posedge clk) disable iff (!rst_n) (&rsync) |-> !bit_vld); // R1
  AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n) (word_end.stb && !word_end.frame_ok) |=> err_frame); // R6
  AST_PARITY_BLOCKS_RDY: assert property (@(posedge clk) disable iff (!rst_n) (word_end.stb && !byte_mode && !word_end.parity_ok && !byte_stb) |=> !$rose(data_rdy)); // R7
  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(err_overrun) |-> ($past(data_rdy) && !$past(rd_ack))); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rd_ack && !byte_stb && !word_end.stb) |=> (!data_rdy && !err_overrun)); // R10
  AST_BYTE_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n) byte_stb |=> (data_out[WORD_BITS-1:BYTE_BITS] == '0)); // R8

endmodule

// File: tb/rxdr_rx_tb.sv
module rxdr_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rail_zero = 1'b0, rail_one = 1'b0;
  logic        byte_mode = 1'b0, parity_en = 1'b1, rd_ack = 1'b0;
  logic [31:0] data_out;
  logic        data_rdy, first_flag, err_parity, err_frame, err_overrun;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rxdr_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rail_zero(rail_zero), .rail_one(rail_one),
    .byte_mode(byte_mode), .parity_en(parity_en), .rd_ack(rd_ack),
    .data_out(data_out), .data_rdy(data_rdy), .first_flag(first_flag),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    rail_zero = !b; rail_one = b;
    repeat (2) @(negedge clk);
    rail_zero = 1'b0; rail_one = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_word(input logic [31:0] w, input int n);
    for (int i = 0; i < n; i++) send_bit(w[i % 32]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
  endtask

  function automatic logic [31:0] mkword(input int i);
    return (i * 32'h9E3779B9) ^ (32'h0135_7BDF << (i % 7));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] w, w2;
    logic        ok, seen;
    int          m;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 reset data", data_out, 32'h0);
    chk("R10 reset flags", {27'h0, data_rdy, first_flag, err_parity, err_frame, err_overrun}, 32'h0);

    // R3: word before first gap is ignored
    send_word(32'h0000_0007, 32);
    idle(24);
    chk("R3 no word before gap", {31'h0, data_rdy}, 32'h0);
    chk("R3 no frame before gap", {31'h0, err_frame}, 32'h0);

    // R4 bit order
    send_word(32'h0000_0001, 32); idle(24);
    chk("R4 first bit lsb", data_out, 32'h0000_0001); ack();
    send_word(32'h8000_0000, 32); idle(24);
    chk("R4 last bit msb", data_out, 32'h8000_0000); ack();

    // R5 / R7 word sweep with parity
    for (int i = 0; i < 24; i++) begin
      w = mkword(i);
      ok = ^w;
      send_word(w, 32); idle(24);
      chk("R5 rdy", {31'h0, data_rdy}, {31'h0, ok});
      chk("R5 first", {31'h0, first_flag}, {31'h0, ok});
      if (ok) chk("R5 data", data_out, w);
      chk("R7 parity flag", {31'h0, err_parity}, {31'h0, !ok});
      chk("R6 no frame", {31'h0, err_frame}, 32'h0);
      ack();
    end

    // R6 framing sweep
    for (int n = 1; n <= 40; n++) begin
      if (n == 32) continue;
      w = mkword(n + 100);
      send_word(w, n); idle(24);
      chk("R6 frame flag", {31'h0, err_frame}, 32'h1);
      chk("R6 no rdy", {31'h0, data_rdy}, 32'h0);
      chk("R6 no parity flag", {31'h0, err_parity}, 32'h0);
      ack();
    end

    // R7 parity disabled, even words accepted with bit 31 as data
    parity_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      w = mkword(i + 200);
      if (^w) w[31] = ~w[31];
      w[31] = 1'b1; w[0] = ~w[0];
      if (^w) w[1] = ~w[1];
      send_word(w, 32); idle(24);
      chk("R7 parity off rdy", {31'h0, data_rdy}, 32'h1);
      chk("R7 parity off data", data_out, w);
      chk("R7 parity off flag", {31'h0, err_parity}, 32'h0);
      ack();
    end
    parity_en = 1'b1;

    // R2 glitches and R1 both-high samples between bits
    w = 32'hA5C3_0F1E; if (!(^w)) w[5] = ~w[5];
    for (int i = 0; i < 32; i++) begin
      send_bit(w[i]);
      if (i % 2 == 0) begin rail_one = 1'b1; idle(1); rail_one = 1'b0; idle(3); end
      else begin rail_zero = 1'b1; idle(1); rail_zero = 1'b0; idle(3); end
      if (i % 5 == 0) begin rail_zero = 1'b1; rail_one = 1'b1; idle(3); rail_zero = 1'b0; rail_one = 1'b0; idle(2); end
    end
    idle(24);
    chk("R2 glitch ignored data", data_out, w);
    chk("R1 both high ignored frame", {30'h0, err_frame, data_rdy}, 32'h1);
    ack();

    // R8 byte mode sweep
    byte_mode = 1'b1;
    for (int i = 0; i < 6; i++) begin
      w = mkword(i + 300);
      ok = ^w;
      for (int b = 0; b < 32; b++) begin
        send_bit(w[b]);
        if (b % 8 == 7) begin
          idle(2);
          chk("R8 byte data", data_out, {24'h0, w[(b-7) +: 8]});
          chk("R8 byte rdy", {31'h0, data_rdy}, 32'h1);
          chk("R8 first byte", {31'h0, first_flag}, {31'h0, b == 7});
          ack();
        end
      end
      idle(24);
      chk("R8 no rdy at end", {31'h0, data_rdy}, 32'h0);
      chk("R8 end parity", {31'h0, err_parity}, {31'h0, !ok});
      chk("R8 end frame", {31'h0, err_frame}, 32'h0);
      ack();
    end
    send_word(mkword(400), 35); idle(24);
    chk("R8 long word frame", {31'h0, err_frame}, 32'h1);
    ack();
    byte_mode = 1'b0;

    // R9 overwrite
    w = 32'h0000_0013; w2 = 32'h0000_0700;
    send_word(w, 32); idle(24);
    send_word(w2, 32); idle(24);
    chk("R9 overrun flag", {31'h0, err_overrun}, 32'h1);
    chk("R9 data replaced", data_out, w2);
    ack(); idle(1);
    chk("R10 ack clears", {27'h0, data_rdy, first_flag, err_parity, err_frame, err_overrun}, 32'h0);

    // R10 / R9 collision sweep of rd_ack around the delivery edge
    for (int o = 6; o < 27; o++) begin
      ack();
      send_word(w, 32); idle(24);
      send_word(w2, 32);
      seen = 1'b0; m = -1;
      for (int j = 0; j < 30; j++) begin
        @(negedge clk);
        if (!seen && data_out == w2) begin seen = 1'b1; m = j; end
        rd_ack = (j == o);
      end
      rd_ack = 1'b0;
      idle(2);
      chk("R10 delivery seen", {31'h0, seen}, 32'h1);
      chk("R10 collision rdy", {31'h0, data_rdy}, {31'h0, (o + 1) <= m});
      chk("R9 collision no overrun", {31'h0, err_overrun}, 32'h0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule